// File: doc/BRIEF.md
# Cyclic Neighbour-Product Sum Extrema Tracker

This block takes a stream of permutations of the integers 1..n, one per clock cycle, flagged by an input valid. For each permutation it forms the cyclic sum of products of neighbouring elements: every element times its right-hand neighbour, with the last used element multiplied by the first to close the ring. It also keeps the smallest and the largest such sum seen so far in the current run.

A run is a contiguous burst of valid permutations. The first valid sum of a run sets both extremes. Later sums in the run widen them. When the input valid drops, the output valid drops three cycles later. Both extremes then stay unchanged until the next run begins, so the results for a complete n can be read once the run is over.

The element count n (2 to 18) and n+1 are both supplied by the source. All 18 element lanes are always present, but lanes at index n and above take no part in the sum.

Top module: `cyc_prod_extrema`

## Requirements
- R1: `sum_out` equals the sum over i = 0..n-2 of e[i]*e[i+1], plus e[n-1]*e[0]. Element i sits in `elem_bus[5*i+4:5*i]` and is read as an unsigned value. The result is 14 bits wide.
- R2: Element lanes with index n or higher have no effect on `sum_out`, `min_out` or `max_out`, whatever their values.
- R3: With n = 2 the sum is twice e[0]*e[1].
- R4: `out_valid` and `sum_out` for a permutation appear three clock edges after the edge that samples it with `in_valid` high. `out_valid` is `in_valid` delayed by three cycles.
- R5: The first valid output of a run (`out_valid` rising) shows `min_out` and `max_out` equal to that output's `sum_out`.
- R6: Within a run, `min_out` and `max_out` show the minimum and the maximum of all sums of the run so far, including the one on `sum_out`.
- R7: While `out_valid` is low, `min_out` and `max_out` hold their last values.
- R8: A gap of at least one cycle in `in_valid` ends the run. The next valid permutation starts a new run, and earlier extremes are discarded.
- R9: A synchronous active-high `rst` clears `out_valid`, `sum_out`, `min_out` and `max_out` to zero.
- R10: Whenever `out_valid` is high, `min_out <= sum_out <= max_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A permutation is presented this cycle |
| n_val | input | 5 | Element count n, 2..18 |
| n_plus1 | input | 5 | n + 1 |
| elem_bus | input | 90 | 18 elements of 5 bits, element i at bits 5*i+4:5*i |
| sum_out | output | 14 | Cyclic neighbour-product sum |
| min_out | output | 14 | Smallest sum of the current or last run |
| max_out | output | 14 | Largest sum of the current or last run |
| out_valid | output | 1 | `sum_out`, `min_out` and `max_out` belong to a valid permutation |

## Verification
Every permutation is due at the ports on the third clock edge after it is sampled, and all of its results appear together: sum, minimum, maximum and valid. The driver stamps each expected item with that due cycle. The monitor samples on the falling edge and flags any output that is early, late or missing. Between runs, the monitor checks on every falling edge that the extremes still equal the last expected pair.

// File: rtl/cps_pkg.sv
package cps_pkg;
    localparam int MAX_N = 18;
    localparam int EW    = 5;
    localparam int PW    = 2 * EW;
    localparam int SW    = 14;
    localparam int BUS_W = MAX_N * EW;
    localparam int LAT   = 3;

    typedef logic [EW-1:0] elem_t;
    typedef logic [PW-1:0] prod_t;
    typedef logic [SW-1:0] sum_t;

    typedef struct packed {
        sum_t lo;
        sum_t hi;
    } extrema_t;

    // Fold one sum into the running pair; a fresh run restarts the pair.
    function automatic extrema_t fold(extrema_t cur, sum_t s, logic fresh);
        extrema_t nx;
        nx = cur;
        if (fresh || s < cur.lo) nx.lo = s;
        if (fresh || s > cur.hi) nx.hi = s;
        return nx;
    endfunction
endpackage

// File: rtl/cps_products.sv
module cps_products
    import cps_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [4:0]               n_val,
    input  logic [4:0]               n_plus1,
    input  logic [BUS_W-1:0]         elem_bus,
    output prod_t [MAX_N-1:0]        prod_q,
    output logic                     vld_q
);
    for (genvar i = 0; i < MAX_N; i++) begin : g_lane
        localparam int NXT = (i + 1) % MAX_N;
        elem_t a, b;
        logic  live, closing;

        assign a       = elem_bus[i*EW +: EW];
        assign closing = (int'(n_val) == i + 1);
        assign live    = (i + 1 < int'(n_plus1));
        assign b       = closing ? elem_bus[0 +: EW] : elem_bus[NXT*EW +: EW];

        always_ff @(posedge clk) begin
            if (rst) prod_q[i] <= '0;
            else     prod_q[i] <= live ? prod_t'(a) * prod_t'(b) : '0;
        end

        // R2: lanes at or beyond n contribute nothing
        a_r2_idle_lane_zero: assert property (@(posedge clk) disable iff (rst)
            (int'(n_val) <= i && int'(n_plus1) == int'(n_val) + 1) |=> (prod_q[i] == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= in_valid;
    end
endmodule

// File: rtl/cps_adder.sv
module cps_adder
    import cps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  prod_t [MAX_N-1:0] prod_in,
    input  logic              vld_in,
    output sum_t              sum_q,
    output logic              vld_q
);
    sum_t acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < MAX_N; i++) acc = acc + sum_t'(prod_in[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            vld_q <= 1'b0;
        end else begin
            sum_q <= acc;
            vld_q <= vld_in;
        end
    end
endmodule

// File: rtl/cps_extrema.sv
module cps_extrema
    import cps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sum_t sum_in,
    input  logic vld_in,
    output sum_t sum_q,
    output sum_t min_q,
    output sum_t max_q,
    output logic vld_q
);
    extrema_t ext_q, ext_d;

    always_comb ext_d = fold(ext_q, sum_in, !vld_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= '0;
            sum_q <= '0;
            vld_q <= 1'b0;
        end else begin
            sum_q <= sum_in;
            vld_q <= vld_in;
            if (vld_in) ext_q <= ext_d;
        end
    end

    assign min_q = ext_q.lo;
    assign max_q = ext_q.hi;

    // R5: a fresh run seeds both extremes with its first sum
    a_r5_first_seeds: assert property (@(posedge clk) disable iff (rst)
        (vld_in && !vld_q) |=> (min_q == sum_q && max_q == sum_q));
    // R6: within a run the extremes only widen
    a_r6_widen_only: assert property (@(posedge clk) disable iff (rst)
        (vld_in && vld_q) |=> (min_q <= $past(min_q) && max_q >= $past(max_q)));
    // R7: no update while no valid sum arrives
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !vld_in |=> ($stable(min_q) && $stable(max_q)));
    // R10: the shown sum lies between the extremes
    a_r10_bounded: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> (min_q <= sum_q && sum_q <= max_q));
endmodule

// File: rtl/cyc_prod_extrema.sv
module cyc_prod_extrema
    import cps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [4:0]       n_val,
    input  logic [4:0]       n_plus1,
    input  logic [BUS_W-1:0] elem_bus,
    output logic [SW-1:0]    sum_out,
    output logic [SW-1:0]    min_out,
    output logic [SW-1:0]    max_out,
    output logic             out_valid
);
    prod_t [MAX_N-1:0] prod_s1;
    logic              vld_s1, vld_s2;
    sum_t              sum_s2;

    cps_products u_products (
        .clk(clk), .rst(rst), .in_valid(in_valid), .n_val(n_val),
        .n_plus1(n_plus1), .elem_bus(elem_bus), .prod_q(prod_s1), .vld_q(vld_s1)
    );

    cps_adder u_adder (
        .clk(clk), .rst(rst), .prod_in(prod_s1), .vld_in(vld_s1),
        .sum_q(sum_s2), .vld_q(vld_s2)
    );

    cps_extrema u_extrema (
        .clk(clk), .rst(rst), .sum_in(sum_s2), .vld_in(vld_s2),
        .sum_q(sum_out), .min_q(min_out), .max_q(max_out), .vld_q(out_valid)
    );

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                   warm_q <= '0;
        else if (warm_q != 2'd3)   warm_q <= warm_q + 2'd1;
    end

    // R4: output valid is the input valid three cycles late
    a_r4_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (out_valid == $past(in_valid, LAT)));
    // R9: reset empties the outputs
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && sum_out == '0 && min_out == '0 && max_out == '0));
endmodule

// File: tb/test_cyc_prod_extrema.sv
module test_cyc_prod_extrema;
    import cps_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [4:0]       n_val = 5'd2;
    logic [4:0]       n_plus1 = 5'd3;
    logic [BUS_W-1:0] elem_bus = '0;
    logic [SW-1:0]    sum_out, min_out, max_out;
    logic             out_valid;

    cyc_prod_extrema i_cyc_prod_extrema (
        .clk(clk), .rst(rst), .in_valid(in_valid), .n_val(n_val), .n_plus1(n_plus1),
        .elem_bus(elem_bus), .sum_out(sum_out), .min_out(min_out), .max_out(max_out),
        .out_valid(out_valid)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    sum;
        int    mn;
        int    mx;
        int    due;
        string tag;
        string mtag;
    } exp_t;

    exp_t  q[$];
    int    cyc = 0;
    int    vectors = 0;
    int    miscompares = 0;
    bit    run_open = 0;
    bit    had_run = 0;
    bit    have_last = 0;
    bit    done = 0;
    int    m_min, m_max, last_min, last_max;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input int n, input int p[MAX_N], input string tag);
        int    s;
        string mt;
        s = 0;
        for (int i = 0; i < n; i++) s += p[i] * p[(i + 1) % n];
        if (!run_open) begin
            m_min = s; m_max = s;
            mt = had_run ? "R8" : "R5";
            run_open = 1; had_run = 1;
        end else begin
            if (s < m_min) m_min = s;
            if (s > m_max) m_max = s;
            mt = "R6";
        end
        @(negedge clk);
        in_valid = 1'b1;
        n_val    = 5'(n);
        n_plus1  = 5'(n + 1);
        for (int i = 0; i < MAX_N; i++)
            elem_bus[i*EW +: EW] = (i < n) ? 5'(p[i]) : 5'(31 - (i % 3));
        q.push_back('{sum: s, mn: m_min, mx: m_max, due: cyc + LAT, tag: tag, mtag: mt});
    endtask

    task automatic gap(input int k);
        run_open = 0;
        repeat (k) begin
            @(negedge clk);
            in_valid = 1'b0;
            elem_bus = {3{$urandom()}};
        end
    endtask

    task automatic shuffled(input int n, input int count, input string tag);
        int p[MAX_N];
        for (int c = 0; c < count; c++) begin
            for (int i = 0; i < MAX_N; i++) p[i] = i + 1;
            for (int i = n - 1; i > 0; i--) begin
                int j, t;
                j = int'($urandom_range(i, 0));
                t = p[i]; p[i] = p[j]; p[j] = t;
            end
            send(n, p, tag);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(0, "R4", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.due, "R4", "result cycle", cyc, e.due);
                    check(int'(sum_out) == e.sum, e.tag, "sum_out", int'(sum_out), e.sum);
                    check(int'(min_out) == e.mn, e.mtag, "min_out", int'(min_out), e.mn);
                    check(int'(max_out) == e.mx, e.mtag, "max_out", int'(max_out), e.mx);
                    check(min_out <= sum_out && sum_out <= max_out, "R10", "sum within extremes",
                          int'(sum_out), int'(min_out));
                    last_min = e.mn; last_max = e.mx; have_last = 1;
                end
            end else begin
                if (q.size() != 0 && q[0].due <= cyc)
                    check(0, "R4", "missing result at cycle", cyc, q[0].due);
                if (have_last) begin
                    check(int'(min_out) == last_min, "R7", "min_out held", int'(min_out), last_min);
                    check(int'(max_out) == last_max, "R7", "max_out held", int'(max_out), last_max);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++; miscompares++;
            $display("FAIL R4 watchdog: actual hung expected drained");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int p[MAX_N];
        // reset with a valid permutation held on the inputs
        in_valid = 1'b1;
        elem_bus = {18{5'd3}};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        check(sum_out == '0, "R9", "sum_out after reset", int'(sum_out), 0);
        check(min_out == '0, "R9", "min_out after reset", int'(min_out), 0);
        check(max_out == '0, "R9", "max_out after reset", int'(max_out), 0);

        // n = 4: identity then shuffles, unused lanes hold large values (R1, R2)
        for (int i = 0; i < MAX_N; i++) p[i] = i + 1;
        send(4, p, "R1");
        shuffled(4, 12, "R2");
        gap(5);

        // n = 2 doubling case (R3)
        p[0] = 2; p[1] = 1;
        send(2, p, "R3");
        p[0] = 1; p[1] = 2;
        send(2, p, "R3");
        gap(1);

        // n = 18 full width: identity, reversed, shuffles (R1)
        for (int i = 0; i < MAX_N; i++) p[i] = i + 1;
        send(18, p, "R1");
        for (int i = 0; i < MAX_N; i++) p[i] = MAX_N - i;
        send(18, p, "R1");
        shuffled(18, 40, "R1");
        gap(7);

        // n = 7 and n = 17 runs separated by a single-cycle gap (R2, R8)
        shuffled(7, 25, "R2");
        gap(1);
        shuffled(17, 20, "R2");
        gap(10);

        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule